// File: doc/BRIEF.md
# Receive Byte Buffer with Fill Thresholds and Interrupt Status

This block holds the bytes a serial engine receives until software collects them. The engine pushes one byte per cycle; software drains the buffer through a 32-bit data port, where each read takes up to four of the oldest bytes, packed little-endian. A status word gives software a ready flag, three fill thresholds, the exact byte count and an empty flag. Software can empty the buffer at any time through a reset register bit.

The block also owns the interrupt status and enable registers. Status bits are set by events in the buffer and by two error inputs from neighbouring logic, and software clears them by writing ones. A single level interrupt is high while any enabled status bit is set. The underrun, bus-response-error and write-overrun bits form an error group, which is summarised on a separate output.

Top module: `rxq_buffer`

## Requirements
- R1: fifo_status_o bit 0 is 1 while at least one byte is held, and bit 11 is 1 while no byte is held.
- R2: fifo_status_o bits 1, 2 and 3 are 1 while at least 16, 32 and 64 bytes are held, in that order.
- R3: fifo_status_o bits 10:4 give the number of bytes held. All other status bits read 0.
- R4: In a cycle with pop_i high, pop_data_o carries the oldest held bytes, the k-th oldest (k = 0..3) at bits 8k+7:8k. Positions with no held byte read 0. At the clock edge, min(count, 4) bytes are removed.
- R5: Capacity is 64 bytes. A push at an edge where 64 bytes are held is dropped and the contents do not change.
- R6: A pop when no byte is held returns 0 and sets interrupt-status bit 0 (underrun). The count stays 0.
- R7: A write to the reset register with data bit 0 = 1 empties the buffer at that edge and drops any push in the same cycle. A write with bit 0 = 0 has no effect.
- R8: Interrupt-status bit 1 is set by an accepted byte and bit 2 by an edge at which at least one byte is held. Bit 3 is set by bus_err_i and bit 11 by wr_ovr_i. Every other bit reads 0.
- R9: Writing ist_clr_data_i with ist_clr_we_i clears each status bit at a 1 position. A bit that is set in the same cycle stays set.
- R10: ien_o holds the last enable write masked to the bits 0, 1, 2, 3 and 11. irq_o is high while any bit of ist_o & ien_o is set.
- R11: err_o is high while any of interrupt-status bits 0, 3 or 11 is set, whatever the enables.
- R12: After reset the buffer is empty and the interrupt status and enable registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Serial engine delivers a byte |
| push_byte_i | input | 8 | Received byte |
| pop_i | input | 1 | Data port read strobe |
| pop_data_o | output | 32 | Up to four packed bytes for the current read |
| fifo_status_o | output | 32 | Ready, thresholds, count, empty |
| fifo_rst_we_i | input | 1 | Write to the buffer reset register |
| fifo_rst_bit_i | input | 1 | Bit 0 of that write |
| bus_err_i | input | 1 | Bus response error event |
| wr_ovr_i | input | 1 | Write-path overrun event |
| ist_clr_we_i | input | 1 | Write to interrupt status (write-1-to-clear) |
| ist_clr_data_i | input | 32 | Bits to clear |
| ien_we_i | input | 1 | Write to interrupt enable |
| ien_wdata_i | input | 32 | New enable value |
| ist_o | output | 32 | Interrupt status |
| ien_o | output | 32 | Interrupt enable |
| irq_o | output | 1 | Level interrupt |
| err_o | output | 1 | Any error-group status bit set |

## Verification
A wrong read pointer or byte count shows first on pop_data_o, in the very cycle of the next read, as a byte out of order or a zero where data was expected, and on the count field of fifo_status_o one cycle after the bad update. A lost or stuck status bit appears on ist_o and irq_o one cycle after the event or clear that should have changed it. The bench therefore compares every output against a byte-queue model on every cycle, so a divergence is reported in the cycle it appears, and it drives the buffer full, empty and through flushes often enough that the boundary counts 0, 4, 16, 32 and 64 are crossed many times.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned IST_UNDERRUN  = 0;
  localparam int unsigned IST_NOT_EMPTY = 1;
  localparam int unsigned IST_READY     = 2;
  localparam int unsigned IST_BUS_ERR   = 3;
  localparam int unsigned IST_WR_OVR    = 11;

  localparam logic [31:0] IST_ERR_MASK  =
    (32'd1 << IST_UNDERRUN) | (32'd1 << IST_BUS_ERR) | (32'd1 << IST_WR_OVR);
  localparam logic [31:0] IST_IMPL_MASK =
    IST_ERR_MASK | (32'd1 << IST_NOT_EMPTY) | (32'd1 << IST_READY);

  localparam int unsigned ST_READY   = 0;
  localparam int unsigned ST_THR_LSB = 1;
  localparam int unsigned ST_NUM_THR = 3;
  localparam int unsigned ST_CNT_LSB = 4;
  localparam int unsigned ST_CNT_W   = 7;
  localparam int unsigned ST_EMPTY   = 11;
  localparam int unsigned THR_BASE   = 16;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [7:0]         push_byte_i,
  input  logic               pop_i,
  input  logic               flush_i,
  output logic [8*LANES-1:0] pop_data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               accept_o,
  output logic               underrun_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q, pop_n;

  assign accept_o   = push_i && !flush_i && (count_q != CNT_W'(DEPTH));
  assign underrun_o = pop_i && (count_q == '0);
  assign pop_n      = !pop_i ? '0 :
                      (count_q >= CNT_W'(LANES)) ? CNT_W'(LANES) : count_q;
  assign count_o    = count_q;

  always_ff @(posedge clk_i) begin
    if (accept_o) mem_q[wr_ptr_q] <= push_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n);
      if (accept_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      count_q  <= count_q - pop_n + CNT_W'(accept_o);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr_q + PTR_W'(g);
    assign pop_data_o[8*g +: 8] = (CNT_W'(g) < count_q) ? mem_q[idx] : 8'h00;
  end

  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_flush_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0);
  p_pop_four_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && count_q >= CNT_W'(LANES))
    |=> count_q == $past(count_q) - CNT_W'(LANES));
  p_underrun_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !push_i) |=> count_q == '0);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [31:0]      status_o
);
  logic [ST_NUM_THR-1:0] thr;

  for (genvar k = 0; k < ST_NUM_THR; k++) begin : g_thr
    assign thr[k] = 32'(count_i) >= (THR_BASE << k);
  end

  always_comb begin
    status_o = '0;
    status_o[ST_READY] = count_i != '0;
    status_o[ST_THR_LSB +: ST_NUM_THR] = thr;
    status_o[ST_CNT_LSB +: ST_CNT_W]   = ST_CNT_W'(count_i);
    status_o[ST_EMPTY] = count_i == '0;
  end
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        underrun_i,
  input  logic        accept_i,
  input  logic        held_i,
  input  logic        bus_err_i,
  input  logic        wr_ovr_i,
  input  logic        clr_we_i,
  input  logic [31:0] clr_data_i,
  input  logic        en_we_i,
  input  logic [31:0] en_data_i,
  output logic [31:0] ist_o,
  output logic [31:0] ien_o,
  output logic        irq_o,
  output logic        err_o
);
  logic [31:0] ist_q, ien_q, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[IST_UNDERRUN]  = underrun_i;
    set_v[IST_NOT_EMPTY] = accept_i;
    set_v[IST_READY]     = held_i;
    set_v[IST_BUS_ERR]   = bus_err_i;
    set_v[IST_WR_OVR]    = wr_ovr_i;
  end
  assign clr_v = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ist_q <= '0;
      ien_q <= '0;
    end else begin
      ist_q <= ((ist_q & ~clr_v) | set_v) & IST_IMPL_MASK;
      if (en_we_i) ien_q <= en_data_i & IST_IMPL_MASK;
    end
  end

  assign ist_o = ist_q;
  assign ien_o = ien_q;
  assign irq_o = |(ist_q & ien_q);
  assign err_o = |(ist_q & IST_ERR_MASK);

  p_underrun_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_i |=> ist_q[IST_UNDERRUN]);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_data_i[IST_BUS_ERR] && !bus_err_i) |=> !ist_q[IST_BUS_ERR]);
  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
  p_err_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((clr_data_i & IST_ERR_MASK) == IST_ERR_MASK)
     && !underrun_i && !bus_err_i && !wr_ovr_i) |=> !err_o);
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LANES = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_valid_i,
  input  logic [7:0]  push_byte_i,
  input  logic        pop_i,
  output logic [31:0] pop_data_o,
  output logic [31:0] fifo_status_o,
  input  logic        fifo_rst_we_i,
  input  logic        fifo_rst_bit_i,
  input  logic        bus_err_i,
  input  logic        wr_ovr_i,
  input  logic        ist_clr_we_i,
  input  logic [31:0] ist_clr_data_i,
  input  logic        ien_we_i,
  input  logic [31:0] ien_wdata_i,
  output logic [31:0] ist_o,
  output logic [31:0] ien_o,
  output logic        irq_o,
  output logic        err_o
);
  logic             flush, accept, underrun;
  logic [CNT_W-1:0] count;

  assign flush = fifo_rst_we_i && fifo_rst_bit_i;

  rxq_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i, .rst_ni,
    .push_i      (push_valid_i),
    .push_byte_i,
    .pop_i,
    .flush_i     (flush),
    .pop_data_o,
    .count_o     (count),
    .accept_o    (accept),
    .underrun_o  (underrun)
  );

  rxq_status #(.CNT_W(CNT_W)) u_status (
    .count_i  (count),
    .status_o (fifo_status_o)
  );

  rxq_irq u_irq (
    .clk_i, .rst_ni,
    .underrun_i (underrun),
    .accept_i   (accept),
    .held_i     (count != '0),
    .bus_err_i, .wr_ovr_i,
    .clr_we_i   (ist_clr_we_i),
    .clr_data_i (ist_clr_data_i),
    .en_we_i    (ien_we_i),
    .en_data_i  (ien_wdata_i),
    .ist_o, .ien_o, .irq_o, .err_o
  );

  p_empty_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_status_o[ST_EMPTY] != fifo_status_o[ST_READY]);
endmodule

// File: tb/rxq_buffer_tb.sv
`timescale 1ns/1ps
module rxq_buffer_tb;
  logic        clk = 0, rst_ni = 0;
  logic        push_valid = 0, pop = 0, frst_we = 0, frst_bit = 0;
  logic        bus_err = 0, wr_ovr = 0, clr_we = 0, ien_we = 0;
  logic [7:0]  push_byte = 0;
  logic [31:0] clr_data = 0, ien_wdata = 0;
  logic [31:0] pop_data, fstat, ist, ien;
  logic        irq, err;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0]  q[$];
  logic [31:0] m_ist = 0, m_ien = 0;
  localparam logic [31:0] IMPL = 32'h0000_080F;
  localparam logic [31:0] ERRM = 32'h0000_0809;

  always #5 clk = ~clk;

  rxq_buffer u_dut (
    .clk_i(clk), .rst_ni, .push_valid_i(push_valid), .push_byte_i(push_byte),
    .pop_i(pop), .pop_data_o(pop_data), .fifo_status_o(fstat),
    .fifo_rst_we_i(frst_we), .fifo_rst_bit_i(frst_bit),
    .bus_err_i(bus_err), .wr_ovr_i(wr_ovr),
    .ist_clr_we_i(clr_we), .ist_clr_data_i(clr_data),
    .ien_we_i(ien_we), .ien_wdata_i(ien_wdata),
    .ist_o(ist), .ien_o(ien), .irq_o(irq), .err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_status(int n);
    logic [31:0] s = '0;
    s[0] = n != 0;
    s[1] = n >= 16; s[2] = n >= 32; s[3] = n >= 64;
    s[10:4] = 7'(n);
    s[11] = n == 0;
    return s;
  endfunction

  function automatic logic [31:0] exp_pop();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) if (k < q.size()) w[8*k +: 8] = q[k];
    return w;
  endfunction

  task automatic check_outputs();
    logic [31:0] es = exp_status(q.size());
    chk("R1", {fstat[11], fstat[0]}, {es[11], es[0]});
    chk("R2", fstat[3:1], es[3:1]);
    chk("R3", fstat, es);
    chk("R8", ist, m_ist);
    chk("R10 enable", ien, m_ien);
    chk("R10 irq", irq, |(m_ist & m_ien));
    chk("R11", err, |(m_ist & ERRM));
  endtask

  // drive at negedge, check pop data, update model, check after edge
  task automatic step();
    logic [31:0] setv = '0;
    int n;
    bit fl, acc;
    #1;
    if (pop) chk("R4", pop_data, exp_pop());
    fl  = frst_we && frst_bit;
    acc = push_valid && !fl && q.size() != 64;
    setv[0] = pop && q.size() == 0;
    setv[1] = acc;
    setv[2] = q.size() != 0;
    setv[3] = bus_err;
    setv[11] = wr_ovr;
    m_ist = ((m_ist & ~(clr_we ? clr_data : 32'h0)) | setv) & IMPL;
    if (ien_we) m_ien = ien_wdata & IMPL;
    if (fl) q.delete();
    else begin
      n = (pop ? ((q.size() < 4) ? q.size() : 4) : 0);
      for (int k = 0; k < n; k++) void'(q.pop_front());
      if (acc) q.push_back(push_byte);
    end
    @(negedge clk);
    {push_valid, pop, frst_we, frst_bit, bus_err, wr_ovr, clr_we, ien_we} = '0;
    check_outputs();
  endtask

  task automatic do_push(logic [7:0] b);
    push_valid = 1; push_byte = b; step();
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R12 status", fstat, 32'h0000_0800);
    chk("R12 ist", ist, 0);
    chk("R12 ien", ien, 0);
    check_outputs();

    // R6: underrun on empty pop
    pop = 1; #1; chk("R6 data", pop_data, 0); step();
    chk("R6 flag", ist[0], 1);
    chk("R6 count", fstat[10:4], 0);

    // R4: partial pop zero-fills
    do_push(8'hA1); do_push(8'hB2); do_push(8'hC3);
    pop = 1; #1; chk("R4 partial", pop_data, 32'h00C3_B2A1); step();
    chk("R4 drained", fstat[10:4], 0);

    // R5: fill to 64, one extra dropped
    for (int i = 0; i < 65; i++) do_push(8'(i));
    chk("R5 count", fstat[10:4], 64);
    chk("R2 full", fstat[3:0], 4'hF);
    pop = 1; #1; chk("R5 head", pop_data, 32'h0302_0100); step();

    // R7: bit0=0 write ignored, bit0=1 empties and drops push
    frst_we = 1; frst_bit = 0; step();
    chk("R7 ignore", fstat[10:4], 60);
    frst_we = 1; frst_bit = 1; push_valid = 1; push_byte = 8'h55; step();
    chk("R7 flush", fstat, 32'h0000_0800);

    // R9: clear all, then set wins over clear
    clr_we = 1; clr_data = '1; step();
    chk("R9 cleared", ist, 0);
    clr_we = 1; clr_data = 32'h8; bus_err = 1; step();
    chk("R9 set wins", ist[3], 1);

    // R10: enable masking
    ien_we = 1; ien_wdata = 32'hFFFF_FFF7; step();
    chk("R10 masked", irq, 0);
    ien_we = 1; ien_wdata = 32'h8; step();
    chk("R10 raised", irq, 1);

    for (int c = 0; c < 6000; c++) begin
      bit fill = ((c / 300) % 2) == 0;
      push_valid = fill ? ($urandom_range(0, 9) < 9) : ($urandom_range(0, 9) < 3);
      push_byte  = 8'($urandom);
      pop        = fill ? ($urandom_range(0, 9) < 2) : ($urandom_range(0, 9) < 6);
      frst_we    = $urandom_range(0, 199) == 0;
      frst_bit   = 1'($urandom);
      bus_err    = $urandom_range(0, 39) == 0;
      wr_ovr     = $urandom_range(0, 39) == 0;
      clr_we     = $urandom_range(0, 7) == 0;
      clr_data   = $urandom;
      ien_we     = $urandom_range(0, 19) == 0;
      ien_wdata  = $urandom;
      step();
    end

    done = 1;
    report();
    $finish;
  end
endmodule